// File: doc/BRIEF.md
# SPI Host Controller with Byte FIFOs

This block is a register-mapped SPI master for a 32-bit bus that makes only word accesses. Software loads bytes into a transmit queue through a data register. A serial engine takes the bytes one at a time, shifts each one out on the serial clock and data-out lines, and samples the data-in line as it goes. Each returned byte is placed in a receive queue, where software reads it back through a second data register. Both queues are eight bytes deep. Bit 31 of the two data registers reports "transmit queue full" and "receive queue empty".

Two watermark comparators set a pair of pending bits. An enable mask combines these pending bits into a single level interrupt. The block also drives a set of active-low chip-select lines. A select register picks the line to use. A mode register decides whether that line is asserted per byte, held asserted, or never asserted. An idle-level register sets the resting level of each line. Writes carrying values that the block cannot honour are discarded without any effect.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset the clock divider reads 0x3, delay register A (0x28) reads 0x1001, delay register B (0x2C) reads 0x1, the chip-select idle register reads all ones for the implemented lines, and every other register reads 0. Both queues are empty, the interrupt is low and all chip selects are high.
- R2: Byte offsets are divider 0x00, clock mode 0x04, select 0x10, idle level 0x14, select mode 0x18, delays 0x28/0x2C, frame format 0x40, TX data 0x48, RX data 0x4C, TX mark 0x50, RX mark 0x54, enable 0x70, pending 0x74. Every other offset, including the flash-control offsets 0x60/0x64 and anything at or above 0x78, reads 0 and ignores writes.
- R3: A write to TX data pushes bits 7:0 when the transmit queue holds fewer than 8 bytes; otherwise the write is dropped. A read of TX data returns 0x80000000 when the queue is full and 0 otherwise.
- R4: A read of RX data returns 0x80000000 when the receive queue is empty. Otherwise it returns the oldest byte in bits 7:0, with bit 31 clear, and removes that byte.
- R5: Each byte is sent MSB first. Every half-period of the serial clock lasts (divider + 1) core cycles. Clock-mode bit 1 sets the idle level of the serial clock (polarity). Clock-mode bit 0 = 0 samples on the leading edge; bit 0 = 1 samples on the trailing edge.
- R6: When frame-format bit 3 is set, received bytes are discarded. A received byte that arrives while the receive queue holds 8 bytes is also discarded.
- R7: Pending bit 0 is 1 when the TX count is strictly below TX mark. Pending bit 1 is 1 when the RX count is strictly above RX mark. Mark writes of 8 or more are ignored, and writes to RX data or to the pending register change nothing.
- R8: The interrupt output is high exactly when some pending bit and the enable bit at the same position are both 1.
- R9: Chip-select lines are active low. When a line is not asserted it rests at its bit in the idle-level register. Select mode 0 (and 1) asserts the selected line while a byte shifts. Mode 2 asserts it continuously. Mode 3 never asserts it.
- R10: A select write of a value at or above the line count is ignored. An idle-level write of a value at or above 2^lines is ignored. A select-mode write above 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low chip selects |
| irq | output | 1 | Level interrupt |

## Verification
A queue pointer or count that goes wrong shows up on the very next register read. The data registers return the bit-31 flag when they should return a byte, or a byte when they should return the flag. The pending register shows a watermark bit that disagrees with the number of bytes written and read. A fault in the serial engine shows up within a single byte: the bench rebuilds each byte from the data-out line at the sampling edge and times the half-period in core cycles. The returned (inverted) byte and the chip-select levels it reads during and after the transfer reveal a wrong phase or a wrong select state before the next byte starts.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int unsigned REG_AW = 7;

  localparam logic [REG_AW-1:0] OFS_DIV    = 7'h00;
  localparam logic [REG_AW-1:0] OFS_MODE   = 7'h04;
  localparam logic [REG_AW-1:0] OFS_CSID   = 7'h10;
  localparam logic [REG_AW-1:0] OFS_CSDEF  = 7'h14;
  localparam logic [REG_AW-1:0] OFS_CSMODE = 7'h18;
  localparam logic [REG_AW-1:0] OFS_DLY0   = 7'h28;
  localparam logic [REG_AW-1:0] OFS_DLY1   = 7'h2C;
  localparam logic [REG_AW-1:0] OFS_FMT    = 7'h40;
  localparam logic [REG_AW-1:0] OFS_TXD    = 7'h48;
  localparam logic [REG_AW-1:0] OFS_RXD    = 7'h4C;
  localparam logic [REG_AW-1:0] OFS_TXMK   = 7'h50;
  localparam logic [REG_AW-1:0] OFS_RXMK   = 7'h54;
  localparam logic [REG_AW-1:0] OFS_IEN    = 7'h70;
  localparam logic [REG_AW-1:0] OFS_IPEND  = 7'h74;

  localparam logic [31:0] FLAG_BIT = 32'h8000_0000;

  // bit position of the "discard received bytes" control in frame format
  localparam int unsigned FMT_DISCARD_BIT = 3;

  typedef enum logic [1:0] {
    CSM_AUTO     = 2'd0,
    CSM_AUTO_ALT = 2'd1,
    CSM_HOLD     = 2'd2,
    CSM_OFF      = 2'd3
  } cs_mode_e;
endpackage

// File: rtl/spi_host_fifo.sv
module spi_host_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic [WIDTH-1:0]               din,
  input  logic                           pop,
  output logic [WIDTH-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic                           full,
  output logic                           empty
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign count   = cnt_q;
  assign dout    = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_ok) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop_ok)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din;
  end
endmodule

// File: rtl/spi_host_shift.sv
module spi_host_shift #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             start_i,
  input  logic [7:0]       byte_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [7:0]       rx_o,
  output logic             sck_o,
  output logic             mosi_o,
  input  logic             miso_i
);
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [3:0]       edge_q, edge_d;
  logic [7:0]       txsr_q, txsr_d, rxsr_q, rxsr_d;
  logic             sck_q, sck_d;
  logic             tick, lead, samp;

  assign tick = (cnt_q >= div_i);
  assign lead = ~edge_q[0];
  // leading edge samples when phase is 0, trailing edge when phase is 1
  assign samp = lead ^ cpha_i;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    edge_d = edge_q;
    txsr_d = txsr_q;
    rxsr_d = rxsr_q;
    sck_d  = sck_q;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        cnt_d  = '0;
        edge_d = '0;
        txsr_d = byte_i;
        sck_d  = cpol_i;
      end
    end else if (tick) begin
      cnt_d  = '0;
      sck_d  = ~sck_q;
      edge_d = edge_q + 1'b1;
      if (samp) begin
        rxsr_d = {rxsr_q[6:0], miso_i};
      end else if (!(cpha_i && edge_q == 4'd0)) begin
        txsr_d = {txsr_q[6:0], 1'b0};
      end
      if (edge_q == 4'd15) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      edge_q <= '0;
      txsr_q <= '0;
      rxsr_q <= '0;
      sck_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      edge_q <= edge_d;
      txsr_q <= txsr_d;
      rxsr_q <= rxsr_d;
      sck_q  <= sck_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = rxsr_q;
  assign sck_o  = busy_q ? sck_q : cpol_i;
  assign mosi_o = txsr_q[7];
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int unsigned NUM_CS     = 2,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned DIV_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [6:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n,
  output logic              irq
);
  localparam int unsigned CNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned MK_W   = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int unsigned CSID_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  logic [DIV_W-1:0]  div_q, div_d;
  logic [1:0]        mode_q, mode_d;
  logic [CSID_W-1:0] csid_q, csid_d;
  logic [NUM_CS-1:0] csdef_q, csdef_d;
  cs_mode_e          csmode_q, csmode_d;
  logic [31:0]       dly0_q, dly0_d, dly1_q, dly1_d, fmt_q, fmt_d;
  logic [MK_W-1:0]   txmk_q, txmk_d, rxmk_q, rxmk_d;
  logic [1:0]        ien_q, ien_d;

  logic              wr, rd;
  logic              tx_push, tx_pop, tx_full, tx_empty;
  logic              rx_push, rx_pop, rx_full, rx_empty;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic [7:0]        tx_dout, rx_dout, eng_rx;
  logic              eng_busy, eng_done;
  logic [1:0]        pend;
  logic              sel_on;

  assign wr = bus_sel & bus_we;
  assign rd = bus_sel & ~bus_we;

  // register next-state
  always_comb begin
    div_d    = div_q;
    mode_d   = mode_q;
    csid_d   = csid_q;
    csdef_d  = csdef_q;
    csmode_d = csmode_q;
    dly0_d   = dly0_q;
    dly1_d   = dly1_q;
    fmt_d    = fmt_q;
    txmk_d   = txmk_q;
    rxmk_d   = rxmk_q;
    ien_d    = ien_q;
    if (wr) begin
      case (bus_addr)
        OFS_DIV:    div_d = bus_wdata[DIV_W-1:0];
        OFS_MODE:   mode_d = bus_wdata[1:0];
        OFS_CSID:   if (bus_wdata < NUM_CS) csid_d = bus_wdata[CSID_W-1:0];
        OFS_CSDEF:  if ({1'b0, bus_wdata} < (33'd1 << NUM_CS)) csdef_d = bus_wdata[NUM_CS-1:0];
        OFS_CSMODE: if (bus_wdata < 32'd4) csmode_d = cs_mode_e'(bus_wdata[1:0]);
        OFS_DLY0:   dly0_d = bus_wdata;
        OFS_DLY1:   dly1_d = bus_wdata;
        OFS_FMT:    fmt_d = bus_wdata;
        OFS_TXMK:   if (bus_wdata < FIFO_DEPTH) txmk_d = bus_wdata[MK_W-1:0];
        OFS_RXMK:   if (bus_wdata < FIFO_DEPTH) rxmk_d = bus_wdata[MK_W-1:0];
        OFS_IEN:    ien_d = bus_wdata[1:0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= DIV_W'(3);
      mode_q   <= '0;
      csid_q   <= '0;
      csdef_q  <= '1;
      csmode_q <= CSM_AUTO;
      dly0_q   <= 32'h0000_1001;
      dly1_q   <= 32'h0000_0001;
      fmt_q    <= '0;
      txmk_q   <= '0;
      rxmk_q   <= '0;
      ien_q    <= '0;
    end else begin
      div_q    <= div_d;
      mode_q   <= mode_d;
      csid_q   <= csid_d;
      csdef_q  <= csdef_d;
      csmode_q <= csmode_d;
      dly0_q   <= dly0_d;
      dly1_q   <= dly1_d;
      fmt_q    <= fmt_d;
      txmk_q   <= txmk_d;
      rxmk_q   <= rxmk_d;
      ien_q    <= ien_d;
    end
  end

  // queue control
  assign tx_push = wr && (bus_addr == OFS_TXD);
  assign tx_pop  = ~eng_busy & ~tx_empty;
  assign rx_pop  = rd && (bus_addr == OFS_RXD) && !rx_empty;
  assign rx_push = eng_done & ~fmt_q[FMT_DISCARD_BIT] & ~rx_full;

  spi_host_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(bus_wdata[7:0]),
    .pop(tx_pop), .dout(tx_dout), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  spi_host_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(eng_rx),
    .pop(rx_pop), .dout(rx_dout), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  spi_host_shift #(.DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .div_i(div_q), .cpol_i(mode_q[1]), .cpha_i(mode_q[0]),
    .start_i(tx_pop), .byte_i(tx_dout), .busy_o(eng_busy), .done_o(eng_done),
    .rx_o(eng_rx), .sck_o(spi_sck), .mosi_o(spi_mosi), .miso_i(spi_miso)
  );

  // watermarks and interrupt
  assign pend[0] = (tx_cnt < CNT_W'(txmk_q));
  assign pend[1] = (rx_cnt > CNT_W'(rxmk_q));
  assign irq     = |(pend & ien_q);

  // chip selects
  assign sel_on = (csmode_q == CSM_HOLD) ||
                  (eng_busy && (csmode_q == CSM_AUTO || csmode_q == CSM_AUTO_ALT));

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign spi_cs_n[i] = (sel_on && csid_q == CSID_W'(i)) ? 1'b0 : csdef_q[i];
  end

  // read mux
  always_comb begin
    case (bus_addr)
      OFS_DIV:    bus_rdata = 32'(div_q);
      OFS_MODE:   bus_rdata = 32'(mode_q);
      OFS_CSID:   bus_rdata = 32'(csid_q);
      OFS_CSDEF:  bus_rdata = 32'(csdef_q);
      OFS_CSMODE: bus_rdata = 32'(csmode_q);
      OFS_DLY0:   bus_rdata = dly0_q;
      OFS_DLY1:   bus_rdata = dly1_q;
      OFS_FMT:    bus_rdata = fmt_q;
      OFS_TXD:    bus_rdata = tx_full ? FLAG_BIT : 32'h0;
      OFS_RXD:    bus_rdata = rx_empty ? FLAG_BIT : {24'h0, rx_dout};
      OFS_TXMK:   bus_rdata = 32'(txmk_q);
      OFS_RXMK:   bus_rdata = 32'(rxmk_q);
      OFS_IEN:    bus_rdata = 32'(ien_q);
      OFS_IPEND:  bus_rdata = 32'(pend);
      default:    bus_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/spi_host_ctrl_chk.sv
module spi_host_ctrl_chk
  import spi_host_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned MK_W       = 3
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           bus_sel,
  input logic                           bus_we,
  input logic [6:0]                     bus_addr,
  input logic [31:0]                    bus_wdata,
  input logic [31:0]                    bus_rdata,
  input logic                           spi_sck,
  input logic                           cpol,
  input logic                           eng_busy,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] tx_cnt,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] rx_cnt,
  input logic [MK_W-1:0]                txmk
);
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);

  logic rx_read;
  assign rx_read = bus_sel && !bus_we && bus_addr == OFS_RXD;

  p_fifo_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(FIFO_DEPTH) && rx_cnt <= CW'(FIFO_DEPTH));

  p_full_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == CW'(FIFO_DEPTH) && eng_busy) |=> tx_cnt == CW'(FIFO_DEPTH));

  p_empty_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_read && rx_cnt == '0) |-> bus_rdata == FLAG_BIT);

  p_sck_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy |-> spi_sck == cpol);

  p_rx_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == CW'(FIFO_DEPTH) && !rx_read) |=> rx_cnt == CW'(FIFO_DEPTH));

  p_mark_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == OFS_TXMK && bus_wdata >= FIFO_DEPTH) |=> $stable(txmk));
endmodule

bind spi_host_ctrl spi_host_ctrl_chk #(.FIFO_DEPTH(FIFO_DEPTH), .MK_W(MK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck), .cpol(mode_q[1]),
  .eng_busy(eng_busy), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .txmk(txmk_q)
);

// File: tb/spi_host_ctrl_tb.sv
module spi_host_ctrl_tb;
  import spi_host_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        sck, mosi, miso;
  logic [NCS-1:0] cs_n;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic tb_cpol = 1'b0, tb_cpha = 1'b0, cap_en = 1'b0;
  logic [7:0] cap = '0;
  int nbits = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign miso = ~mosi;

  spi_host_ctrl #(.NUM_CS(NCS), .FIFO_DEPTH(8), .DIV_W(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .spi_cs_n(cs_n), .irq(irq)
  );

  // rebuild bytes from the data-out line at the sampling edge
  always @(sck) begin
    if (cap_en) begin
      if (((sck != tb_cpol) && !tb_cpha) || ((sck == tb_cpol) && tb_cpha)) begin
        cap = {cap[6:0], mosi};
        nbits++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  b;
    int          n;
    logic        prev;
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 cs_n", 32'(cs_n), 32'h3);
    rd(OFS_DIV, d);   chk("R1 divider", d, 32'h3);
    rd(OFS_DLY0, d);  chk("R1 delay A", d, 32'h1001);
    rd(OFS_DLY1, d);  chk("R1 delay B", d, 32'h1);
    rd(OFS_CSDEF, d); chk("R1 idle level", d, 32'h3);
    rd(OFS_MODE, d);  chk("R1 clock mode", d, 32'h0);
    rd(OFS_IPEND, d); chk("R1 pending", d, 32'h0);
    rd(OFS_TXD, d);   chk("R3 tx not full", d, 32'h0);
    rd(OFS_RXD, d);   chk("R4 rx empty", d, FLAG_BIT);

    // R2 reserved and unsupported offsets
    wr(7'h08, 32'hFFFF_FFFF); rd(7'h08, d); chk("R2 reserved", d, 32'h0);
    wr(7'h60, 32'h0000_00FF); rd(7'h60, d); chk("R2 flash ctrl", d, 32'h0);
    wr(7'h7C, 32'h0000_00FF); rd(7'h7C, d); chk("R2 beyond map", d, 32'h0);
    wr(OFS_FMT, 32'h0000_0005); rd(OFS_FMT, d); chk("R2 frame format", d, 32'h5);
    wr(OFS_FMT, 32'h0);

    // R5 R9 sweep over all four clock modes
    wr(OFS_DIV, 32'd2);
    wr(OFS_CSID, 32'd1);
    for (int m = 0; m < 4; m++) begin
      b = 8'h5A ^ 8'(m * 8'h33);
      cap_en = 1'b0;
      tb_cpol = m[1]; tb_cpha = m[0];
      wr(OFS_MODE, 32'(m));
      idle(2);
      chk("R5 sck idle level", 32'(sck), 32'(tb_cpol));
      cap = '0; nbits = 0; cap_en = 1'b1;
      wr(OFS_TXD, {24'hFFFFFF, b});
      idle(6);
      chk("R9 auto select during byte", 32'(cs_n), 32'h1);
      idle(70);
      chk("R5 msb first", 32'(cap), 32'(b));
      chk("R5 bit count", 32'(nbits), 32'd8);
      chk("R9 auto select after byte", 32'(cs_n), 32'h3);
      rd(OFS_RXD, d); chk("R4 received byte", d, {24'h0, ~b});
    end

    // R5 half-period timing
    cap_en = 1'b0; tb_cpol = 1'b0; tb_cpha = 1'b0;
    wr(OFS_MODE, 32'd0);
    wr(OFS_DIV, 32'd5);
    wr(OFS_TXD, 32'h3C);
    prev = sck;
    while (sck == prev) @(negedge clk);
    prev = sck; n = 0;
    while (sck == prev) begin @(negedge clk); n++; end
    chk("R5 half period", 32'(n), 32'd6);
    idle(120);
    rd(OFS_RXD, d); chk("R4 received after timing", d, 32'h0000_00C3);

    // R6 discard direction
    wr(OFS_FMT, 32'h8);
    cap = '0; cap_en = 1'b1;
    wr(OFS_TXD, 32'h77);
    idle(130);
    chk("R6 byte still sent", 32'(cap), 32'h77);
    rd(OFS_RXD, d); chk("R6 discarded", d, FLAG_BIT);
    wr(OFS_FMT, 32'h0);

    // R7 R8 tx watermark sweep with empty queue
    wr(OFS_DIV, 32'd20);
    wr(OFS_IEN, 32'd1);
    for (int m = 0; m < 8; m++) begin
      wr(OFS_TXMK, 32'(m));
      rd(OFS_IPEND, d);
      chk("R7 tx mark empty", 32'(d[0]), 32'(m > 0));
      chk("R8 irq from tx mark", 32'(irq), 32'(m > 0));
    end
    wr(OFS_TXMK, 32'd5);
    wr(OFS_TXMK, 32'd9);
    rd(OFS_TXMK, d); chk("R7 mark reject", d, 32'd5);
    wr(OFS_TXMK, 32'd0);
    wr(OFS_IEN, 32'd0);

    // R3 R6 fill both queues past capacity
    cap = '0; nbits = 0; cap_en = 1'b1;
    for (int i = 0; i < 9; i++) wr(OFS_TXD, 32'(8'hC1 + 8'(i * 7)));
    rd(OFS_TXD, d); chk("R3 tx full flag", d, FLAG_BIT);
    wr(OFS_TXD, 32'hEE);
    for (int m = 0; m < 8; m++) begin
      wr(OFS_TXMK, 32'(m));
      rd(OFS_IPEND, d);
      chk("R7 tx mark full", 32'(d[0]), 32'h0);
    end
    wr(OFS_TXMK, 32'd0);
    idle(3600);
    chk("R3 write to full dropped", 32'(nbits), 32'd72);
    rd(OFS_TXD, d); chk("R3 tx drained", d, 32'h0);

    wr(OFS_RXMK, 32'd3);
    wr(OFS_IEN, 32'd2);
    chk("R8 irq from rx mark", 32'(irq), 32'h1);
    wr(OFS_IEN, 32'd0);
    chk("R8 irq masked", 32'(irq), 32'h0);
    wr(OFS_IPEND, 32'h3);
    rd(OFS_IPEND, d); chk("R7 pending read only", d, 32'h2);
    wr(OFS_RXD, 32'h0);

    // R4 R6 R7 rx watermark sweep while draining
    for (int c = 8; c >= 0; c--) begin
      for (int m = 0; m < 8; m++) begin
        wr(OFS_RXMK, 32'(m));
        rd(OFS_IPEND, d);
        chk("R7 rx mark", 32'(d[1]), 32'(c > m));
      end
      rd(OFS_RXD, d);
      if (c > 0) chk("R6 rx order", d, {24'h0, ~(8'hC1 + 8'((8 - c) * 7))});
      else       chk("R6 ninth byte dropped", d, FLAG_BIT);
    end

    // R9 R10 chip-select control
    wr(OFS_CSID, 32'd2);  rd(OFS_CSID, d);   chk("R10 select reject", d, 32'd1);
    wr(OFS_CSMODE, 32'd4); rd(OFS_CSMODE, d); chk("R10 mode reject", d, 32'd0);
    wr(OFS_CSMODE, 32'd2);
    idle(2);
    chk("R9 hold while idle", 32'(cs_n), 32'h1);
    wr(OFS_CSMODE, 32'd3);
    wr(OFS_TXD, 32'h11);
    idle(30);
    chk("R9 off during byte", 32'(cs_n), 32'h3);
    idle(400);
    rd(OFS_RXD, d); chk("R4 byte in off mode", d, 32'h0000_00EE);
    wr(OFS_CSMODE, 32'd0);
    wr(OFS_CSDEF, 32'd4); rd(OFS_CSDEF, d); chk("R10 idle level reject", d, 32'h3);
    wr(OFS_CSDEF, 32'd2);
    idle(2);
    chk("R9 idle level", 32'(cs_n), 32'h2);
    wr(OFS_TXD, 32'h22);
    idle(30);
    chk("R9 select over idle level", 32'(cs_n), 32'h0);
    idle(400);
    chk("R9 back to idle level", 32'(cs_n), 32'h2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule